// File: doc/BRIEF.md
# Analog Input Command Sequencer

This block turns one sample request into the register traffic that a multiplexed 16-bit ADC with an 8-bit register port expects. A request carries a channel number from 0 to 15, a 2-bit input range code and a differential/single-ended flag. From these the block forms a command byte and picks one of two register banks. It then runs two full conversions with the same command. The first conversion only lets the input multiplexer settle, and its result is never read. After the second conversion the block reads the result as two bytes, corrects the offset for bipolar ranges, and presents the 16-bit sample on its output stream.

Requests enter through a valid/ready port. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the channel, range and mode fields are captured on that edge. Results leave through a valid/ready port. `res_valid`, `res_data` and `res_err` stay fixed until `res_ready` is seen high at a clock edge. While a result waits, no new request is accepted, so a stalled consumer back-pressures the producer with no buffering in between. Each wait for ADC ready is bounded. If the status register never signals completion, the block returns a result with the error flag set and a zero sample.

The register port uses single-cycle read and write strobes on a 3-bit byte address. Read data is expected on `bus_rdata` in the cycle after a read strobe.

Top module: `ai_cmd_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `res_valid` is 0. `req_ready` is 1 only while no request is in progress and no result is waiting. A request is accepted on an edge where `req_valid` and `req_ready` are both 1.
- R2: The command byte is built from the bank-local channel c (the channel modulo 8). Bit 7 is 1 for single-ended mode (`req_diff`=0) and 0 for differential mode. Bit 6 equals bit 0 of c. Bits 5:4 hold c/2. Bits 3:2 hold the range code. Bits 1:0 are 0.
- R3: Channels 0 to 7 use addresses 0 to 3, and channels 8 to 15 use addresses 4 to 7. Within a bank, the command is written at +2, status is read at +3, the low result byte is read at +0 and the high byte at +1.
- R4: Each sample writes the same command byte exactly twice. The block waits for ready after each write. The result bytes are read only after the second ready, so the first conversion's data is discarded.
- R5: For range codes 0 and 1 (bipolar, ±5 V and ±10 V), the returned sample is the raw 16-bit value plus 0x8000 modulo 2^16. For codes 2 and 3 (0–5 V and 0–10 V) the raw value is returned unchanged. The raw value is {high byte, low byte}.
- R6: Conversion is complete when bit 7 of the status byte is 1. A ready indication on the last permitted poll (poll number TIMEOUT_POLLS, default 100000) still counts as success.
- R7: If TIMEOUT_POLLS status reads in one wait phase all show bit 7 clear, the block stops. It issues no further writes and no data reads, and it returns `res_valid` with `res_err`=1 and `res_data`=0.
- R8: While `res_valid` is 1 and `res_ready` is 0, the output stays valid and `res_data` and `res_err` do not change. The output clears on the edge after `res_ready` is seen.
- R9: No read or write strobe is raised while the block is idle, and a read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_chan | input | 4 | Channel 0 to 15 |
| req_range | input | 2 | Range code (0,1 bipolar; 2,3 unipolar) |
| req_diff | input | 1 | 1 = differential, 0 = single-ended |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes result |
| res_data | output | 16 | Corrected sample, zero on error |
| res_err | output | 1 | Ready polling timed out |
| bus_addr | output | 3 | Register byte address |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wdata | output | 8 | Write data (command byte) |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
The hardest cases to reach from the ports are the edges of the timeout window: the last poll that still succeeds and the first one that fails. The bench's ADC model is told after how many status reads in each phase it should report ready. It is set to exactly the poll limit (lowered by a parameter) to show success on the final poll, and to one more than the limit to force the error path. The same model returns a distinctive junk value for the first conversion and counts any data read made before the second command write, so a design that skips the settling conversion or reads early is caught.

// File: rtl/ai_cmd_seq_pkg.sv
package ai_cmd_seq_pkg;
  localparam int BYTE_W   = 8;
  localparam int SAMPLE_W = 2 * BYTE_W;
  localparam int ADDR_W   = 3;
  localparam int CHAN_W   = 4;
  localparam int RANGE_W  = 2;

  localparam logic [1:0] OFS_LO   = 2'd0;
  localparam logic [1:0] OFS_HI   = 2'd1;
  localparam logic [1:0] OFS_CMD  = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  localparam int STAT_DONE_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_PREQ,
    ST_PCHK,
    ST_RLO,
    ST_RHI,
    ST_HCAP,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic [CHAN_W-1:0]  chan;
    logic [RANGE_W-1:0] rng;
    logic               diff;
  } req_t;
endpackage

// File: rtl/ai_cmd_enc.sv
module ai_cmd_enc
  import ai_cmd_seq_pkg::*;
(
  input  req_t              req,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              bank_hi,
  output logic              bipolar
);
  logic [CHAN_W-2:0] local_ch;

  always_comb begin
    bank_hi  = req.chan[CHAN_W-1];
    local_ch = req.chan[CHAN_W-2:0];
    cmd_byte = '0;
    cmd_byte[7]   = ~req.diff;
    cmd_byte[6]   = local_ch[0];
    cmd_byte[5:4] = local_ch[2:1];
    cmd_byte[3:2] = req.rng;
    bipolar  = ~req.rng[1];
  end
endmodule

// File: rtl/ai_poll_timer.sv
module ai_poll_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/ai_result_asm.sv
module ai_result_asm
  import ai_cmd_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_lo,
  input  logic                cap_hi,
  input  logic                zero,
  input  logic                bipolar,
  input  logic [BYTE_W-1:0]   rdata,
  output logic [SAMPLE_W-1:0] sample
);
  localparam logic [SAMPLE_W-1:0] WRAP = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic [BYTE_W-1:0]   lo_q;
  logic [SAMPLE_W-1:0] raw;

  assign raw = {rdata, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      sample <= '0;
    end else begin
      if (cap_lo) lo_q <= rdata;
      if (zero)        sample <= '0;
      else if (cap_hi) sample <= bipolar ? raw + WRAP : raw;
    end
  end
endmodule

// File: rtl/ai_cmd_seq.sv
module ai_cmd_seq
  import ai_cmd_seq_pkg::*;
#(
  parameter int TIMEOUT_POLLS = 100000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CHAN_W-1:0]   req_chan,
  input  logic [RANGE_W-1:0]  req_range,
  input  logic                req_diff,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [SAMPLE_W-1:0] res_data,
  output logic                res_err,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_wr,
  output logic                bus_rd,
  output logic [BYTE_W-1:0]   bus_wdata,
  input  logic [BYTE_W-1:0]   bus_rdata
);
  seq_state_t        state, state_nx;
  req_t              req_q;
  logic              second_q;
  logic              err_q;
  logic [BYTE_W-1:0] cmd_byte;
  logic              bank_hi;
  logic              bipolar;
  logic              poll_last;
  logic              stat_done;
  logic              accept;
  logic [1:0]        ofs;

  ai_cmd_enc u_enc (
    .req      (req_q),
    .cmd_byte (cmd_byte),
    .bank_hi  (bank_hi),
    .bipolar  (bipolar)
  );

  assign stat_done = bus_rdata[STAT_DONE_BIT];

  ai_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state == ST_CMD),
    .step  ((state == ST_PCHK) && !stat_done),
    .last  (poll_last)
  );

  ai_result_asm u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_lo  (state == ST_RHI),
    .cap_hi  (state == ST_HCAP),
    .zero    ((state == ST_PCHK) && !stat_done && poll_last),
    .bipolar (bipolar),
    .rdata   (bus_rdata),
    .sample  (res_data)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign res_valid = (state == ST_DONE);
  assign res_err   = err_q;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (accept) state_nx = ST_CMD;
      ST_CMD:  state_nx = ST_PREQ;
      ST_PREQ: state_nx = ST_PCHK;
      ST_PCHK: begin
        if (stat_done)      state_nx = second_q ? ST_RLO : ST_CMD;
        else if (poll_last) state_nx = ST_DONE;
        else                state_nx = ST_PREQ;
      end
      ST_RLO:  state_nx = ST_RHI;
      ST_RHI:  state_nx = ST_HCAP;
      ST_HCAP: state_nx = ST_DONE;
      ST_DONE: if (res_ready) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_q    <= '0;
      second_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        req_q    <= '{chan: req_chan, rng: req_range, diff: req_diff};
        second_q <= 1'b0;
        err_q    <= 1'b0;
      end
      if (state == ST_PCHK && stat_done)               second_q <= 1'b1;
      if (state == ST_PCHK && !stat_done && poll_last) err_q    <= 1'b1;
    end
  end

  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = '0;
    ofs       = OFS_LO;
    case (state)
      ST_CMD:  begin bus_wr = 1'b1; bus_wdata = cmd_byte; ofs = OFS_CMD; end
      ST_PREQ: begin bus_rd = 1'b1; ofs = OFS_STAT; end
      ST_RLO:  begin bus_rd = 1'b1; ofs = OFS_LO; end
      ST_RHI:  begin bus_rd = 1'b1; ofs = OFS_HI; end
      default: ;
    endcase
    bus_addr = {bank_hi, ofs};
  end
endmodule

// File: rtl/ai_cmd_seq_chk.sv
module ai_cmd_seq_chk
  import ai_cmd_seq_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                res_valid,
  input logic                res_ready,
  input logic [SAMPLE_W-1:0] res_data,
  input logic                res_err,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_err));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid);

  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err |-> res_data == '0);

  p_no_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_wr && !bus_rd);

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  p_cmd_ofs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_addr[1:0] == OFS_CMD);
endmodule

bind ai_cmd_seq ai_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_err   (res_err),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd)
);

// File: tb/test_ai_cmd_seq.sv
`timescale 1ns/1ps
module test_ai_cmd_seq;
  localparam int TMO = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_chan = '0;
  logic [1:0]  req_range = '0;
  logic        req_diff = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_data;
  logic        res_err;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = '0;

  always #2.5 clk = ~clk;

  ai_cmd_seq #(.TIMEOUT_POLLS(TMO)) i_ai_cmd_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_range(req_range), .req_diff(req_diff),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_err(res_err),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  // ADC register model
  int          m_delay = 0;
  logic [15:0] m_sample = '0;
  logic        m_bank = 1'b0;
  int          m_wr = 0;
  int          m_seen = 0;
  logic [7:0]  m_cmd1 = '0, m_cmd2 = '0;
  int          m_bad_addr = 0;
  int          m_early = 0;
  int          m_data_rd = 0;
  int          m_idle_act = 0;
  logic        m_watch_idle = 1'b0;
  localparam logic [15:0] JUNK = 16'hDEAD;

  always @(posedge clk) begin
    if (m_watch_idle && (bus_wr || bus_rd)) m_idle_act <= m_idle_act + 1;
    if (bus_wr || bus_rd) begin
      if (bus_addr[2] != m_bank) m_bad_addr <= m_bad_addr + 1;
    end
    if (bus_wr) begin
      if (bus_addr[1:0] != 2'd2) m_bad_addr <= m_bad_addr + 1;
      if (m_wr == 0) m_cmd1 <= bus_wdata;
      else           m_cmd2 <= bus_wdata;
      m_wr   <= m_wr + 1;
      m_seen <= 0;
    end
    if (bus_rd) begin
      case (bus_addr[1:0])
        2'd3: begin
          m_seen    <= m_seen + 1;
          bus_rdata <= {(m_seen + 1 >= m_delay), 7'h15};
        end
        2'd0: begin
          m_data_rd <= m_data_rd + 1;
          if (m_wr < 2) m_early <= m_early + 1;
          bus_rdata <= (m_wr < 2) ? JUNK[7:0] : m_sample[7:0];
        end
        2'd1: begin
          m_data_rd <= m_data_rd + 1;
          if (m_wr < 2) m_early <= m_early + 1;
          bus_rdata <= (m_wr < 2) ? JUNK[15:8] : m_sample[15:8];
        end
        default: begin
          bus_rdata <= 8'h00;
          m_bad_addr <= m_bad_addr + 1;
        end
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cmd(input logic [3:0] ch, input logic [1:0] rg, input logic df);
    int c = ch % 8;
    return (df ? 8'h00 : 8'h80) | ((c % 2) ? 8'h40 : 8'h00) |
           8'(((c / 2) % 4) << 4) | 8'(rg << 2);
  endfunction

  task automatic issue(input logic [3:0] ch, input logic [1:0] rg, input logic df,
                       input logic [15:0] raw, input int dly);
    @(negedge clk);
    m_wr = 0; m_seen = 0; m_early = 0; m_data_rd = 0; m_bad_addr = 0;
    m_delay = dly; m_sample = raw; m_bank = ch[3];
    req_chan = ch; req_range = rg; req_diff = df; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_res();
    for (int i = 0; i < 2000; i++) begin
      if (res_valid) return;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "req_ready after reset", req_ready, 1);
    chk("R1", "res_valid after reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_sample(input logic [3:0] ch, input logic [1:0] rg, input logic df,
                          input logic [15:0] raw, input int dly);
    logic [15:0] exp_d;
    exp_d = (rg < 2) ? raw + 16'h8000 : raw;
    issue(ch, rg, df, raw, dly);
    chk("R1", "req_ready while busy", req_ready, 0);
    wait_res();
    chk("R5", "sample value", res_data, exp_d);
    chk("R6", "error flag clear", res_err, 0);
    chk("R2", "command byte", m_cmd1, exp_cmd(ch, rg, df));
    chk("R4", "second command equal", m_cmd2, exp_cmd(ch, rg, df));
    chk("R4", "two command writes", m_wr, 2);
    chk("R4", "no data read before second write", m_early, 0);
    chk("R3", "bank and offsets", m_bad_addr, 0);
    chk("R3", "two data reads", m_data_rd, 2);
    @(negedge clk);
  endtask

  task automatic t_timeout();
    issue(4'd9, 2'd0, 1'b0, 16'h1234, TMO + 1);
    wait_res();
    chk("R7", "res_valid on timeout", res_valid, 1);
    chk("R7", "error flag", res_err, 1);
    chk("R7", "zero data", res_data, 0);
    chk("R7", "single command write", m_wr, 1);
    chk("R7", "no data reads", m_data_rd, 0);
    @(negedge clk);
  endtask

  task automatic t_backpressure();
    logic [15:0] held;
    res_ready = 1'b0;
    issue(4'd6, 2'd3, 1'b1, 16'h4321, 2);
    wait_res();
    held = res_data;
    repeat (5) @(negedge clk);
    chk("R8", "valid held", res_valid, 1);
    chk("R8", "data held", res_data, held);
    chk("R8", "data value", held, 16'h4321);
    chk("R1", "no accept while result waits", req_ready, 0);
    res_ready = 1'b1;
    @(negedge clk);
    chk("R8", "valid cleared after handoff", res_valid, 0);
    chk("R1", "ready after handoff", req_ready, 1);
  endtask

  task automatic t_idle();
    m_idle_act = 0;
    m_watch_idle = 1'b1;
    repeat (10) @(negedge clk);
    m_watch_idle = 1'b0;
    chk("R9", "no bus activity while idle", m_idle_act, 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sample(4'd0, 2'd0, 1'b0, 16'h0000, 1);
    t_sample(4'd5, 2'd1, 1'b1, 16'h9ABC, 3);
    t_sample(4'd10, 2'd2, 1'b0, 16'h8001, 0);
    t_sample(4'd15, 2'd3, 1'b1, 16'hFFFF, 4);
    t_sample(4'd8, 2'd1, 1'b0, 16'h7FFF, TMO);  // R6 success on last poll
    t_timeout();
    t_backpressure();
    t_idle();
    t_sample(4'd3, 2'd0, 1'b0, 16'hC0DE, 2);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule